// File: doc/BRIEF.md
# Flash Block Programming Sequencer

This block controls writes into an on-chip program memory from a small processor core. Software loads the eight bytes of a programming block one at a time through table writes. Each byte lands in a byte-wide holding latch chosen by the three low bits of a table pointer. No table write touches the array; it only fills a latch.

The array is written only through a guarded commit. Software writes 0x55 and then 0xAA to a key register, and its next access must be a control write with the start bit set. If the control value enables writing and selects program memory, a timed long write begins. The processor is held by the stall output until the programming timer expires. The eight latched bytes are then copied into the block named by the upper pointer bits. The latches then return to the erased value 0xFF.

A 64-byte row is updated by an erase followed by eight such block commits. The timer length is a parameter, so that simulation can use a short count in place of the millisecond-scale silicon time.

Top module: `flw_seq`

## Requirements
- R1: After reset, stall is 0, the control readback is 0x00, the table pointer is 0, and every array byte reads 0xFF.
- R2: A table write stores its byte in the holding latch selected by pointer bits [2:0]. The pointer advances by one only when the increment input is set with the write. A pointer load replaces the pointer. No table write changes the array.
- R3: The sequence of key byte 0x55, key byte 0xAA, then a control write with start (bit 0), write enable (bit 1) and program select (bit 2) set and configuration select (bit 3) clear raises stall on the next cycle.
- R4: A wrong key byte, a table write, a pointer load, or a control write without start anywhere in the sequence returns it to idle. A start write without a completed sequence leaves stall low, leaves the start bit reading 0 and leaves the array unchanged.
- R5: An unlocked start with program select clear or configuration select set starts nothing and leaves the error flag unchanged.
- R6: An unlocked start with write enable clear sets the error flag (readback bit 4), raises no stall and leaves the array unchanged.
- R7: Stall stays high for exactly PROG_CYCLES cycles, and the start bit reads 1 during that time. When stall falls, the start bit reads 0.
- R8: When stall falls, array bytes base+0 through base+7 hold latches 0 through 7, where base is the pointer with bits [2:0] cleared. No other array byte changes.
- R9: After a commit, every latch reads 0xFF, so a block reloaded only in part programs 0xFF into each byte it did not load.
- R10: While stall is high, table writes, pointer loads, key writes and control writes have no effect.
- R11: A commit that starts clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_ld | input | 1 | Load the table pointer |
| ptr_wdata | input | ADDR_W | New table pointer value |
| tw_we | input | 1 | Table write strobe |
| tw_data | input | 8 | Table write byte |
| tw_inc | input | 1 | Post-increment the pointer on this table write |
| key_we | input | 1 | Key register write strobe |
| key_data | input | 8 | Key byte |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value: bit0 start, bit1 write enable, bit2 program select, bit3 configuration select |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |
| ptr_o | output | ADDR_W | Current table pointer |
| ctl_rdata | output | 8 | Control readback: bits 3..0 as written, bit4 error flag |
| stall | output | 1 | Processor hold during the long write |

## Verification
The assertions assume that at most one of key, table, pointer and control accesses is presented in any cycle, as a processor issuing one instruction at a time would do. Simultaneous strobes are not given a defined priority. They also assume that PROG_CYCLES is at least one. The bench issues each access as a one-cycle strobe followed by an idle cycle, so the unlock sequence is never broken by overlapping strobes. The accesses it drives during stall are issued only to check that they are ignored.

// File: rtl/flw_pkg.sv
package flw_pkg;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_GOT1  = 2'd1,
    UL_ARMED = 2'd2
  } ul_state_t;

  // control register image, bit 0 is start
  typedef struct packed {
    logic err;
    logic cfg_sel;
    logic prog_sel;
    logic wren;
    logic start;
  } ctl_t;

  function automatic ctl_t ctl_from_bus(input logic [7:0] w);
    ctl_t c;
    c.start    = w[0];
    c.wren     = w[1];
    c.prog_sel = w[2];
    c.cfg_sel  = w[3];
    c.err      = 1'b0;
    return c;
  endfunction

  function automatic logic aims_at_program(input ctl_t c);
    return c.prog_sel && !c.cfg_sel;
  endfunction

  function automatic logic [7:0] ctl_to_bus(input ctl_t c);
    return {3'b000, c};
  endfunction

endpackage

// File: rtl/flw_unlock.sv
module flw_unlock
  import flw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       key_we,
  input  logic [7:0] key_data,
  input  logic       other_acc,
  input  logic       start_wr,
  output logic       armed_hit,
  output ul_state_t  state_o
);

  ul_state_t state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= UL_IDLE;
    end else if (en) begin
      if (key_we) begin
        case (state_q)
          UL_IDLE: state_q <= (key_data == KEY_FIRST)  ? UL_GOT1  : UL_IDLE;
          UL_GOT1: state_q <= (key_data == KEY_SECOND) ? UL_ARMED : UL_IDLE;
          default: state_q <= UL_IDLE;
        endcase
      end else if (other_acc || start_wr) begin
        state_q <= UL_IDLE;
      end
    end
  end

  assign armed_hit = en && start_wr && (state_q == UL_ARMED);
  assign state_o   = state_q;

  // R3: armed only directly after the second key byte (or held while frozen)
  p_armed_after_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == UL_ARMED) |->
      ($past(state_q) == UL_ARMED) ||
      $past(en && key_we && key_data == KEY_SECOND && state_q == UL_GOT1));

  // R4: wrong second byte falls back to idle
  p_bad_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && key_we && state_q == UL_GOT1 && key_data != KEY_SECOND) |=> (state_q == UL_IDLE));

  // R4: intervening access drops any progress
  p_intervene_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !key_we && other_acc) |=> (state_q == UL_IDLE));

endmodule

// File: rtl/flw_timer.sv
module flw_timer #(
  parameter int PROG_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (go && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(PROG_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  // R7: a start request never arrives while already running
  p_go_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q);

  // R7: the write keeps running until the count is spent
  p_run_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);

  // R7: the write ends only through the terminal count
  p_end_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done));

endmodule

// File: rtl/flw_holding.sv
module flw_holding #(
  parameter int ADDR_W = 6,
  parameter int HOLD_N = 8
) (
  input  logic                 clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                ptr_ld,
  input  logic [ADDR_W-1:0]   ptr_wdata,
  input  logic                tw_we,
  input  logic [7:0]          tw_data,
  input  logic                tw_inc,
  input  logic                refill,
  output logic [ADDR_W-1:0]   ptr_o,
  output logic [HOLD_N*8-1:0] hold_flat
);

  localparam int SLOT_W = $clog2(HOLD_N);

  logic [ADDR_W-1:0] ptr_q;
  logic [7:0]        hold_q [HOLD_N];
  logic [SLOT_W-1:0] slot;

  assign slot = ptr_q[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < HOLD_N; i++) hold_q[i] <= 8'hFF;
    end else if (refill) begin
      for (int i = 0; i < HOLD_N; i++) hold_q[i] <= 8'hFF;
    end else if (en) begin
      if (ptr_ld) begin
        ptr_q <= ptr_wdata;
      end else if (tw_we) begin
        hold_q[slot] <= tw_data;
        if (tw_inc) ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < HOLD_N; g++) begin : g_flat
    assign hold_flat[g*8 +: 8] = hold_q[g];
  end

  assign ptr_o = ptr_q;

  // R9: latches read erased after a commit finishes
  p_refill_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(refill) |-> (hold_flat == '1));

  // R10: pointer frozen while the core is held
  p_ptr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> $stable(ptr_q));

endmodule

// File: rtl/flw_array.sv
module flw_array #(
  parameter int ADDR_W = 6,
  parameter int HOLD_N = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-$clog2(HOLD_N)-1:0] blk,
  input  logic [HOLD_N*8-1:0]        wdata_flat,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [7:0]                 rd_data
);

  localparam int SLOT_W = $clog2(HOLD_N);
  localparam int DEPTH  = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= 8'hFF;
    end else if (we) begin
      for (int i = 0; i < HOLD_N; i++)
        mem_q[{blk, SLOT_W'(i)}] <= wdata_flat[i*8 +: 8];
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R8: first byte of the block carries latch 0 after a commit
  p_block_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[{$past(blk), SLOT_W'(0)}] == $past(wdata_flat[7:0])));

  // R8: last byte of the block carries the last latch
  p_block_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[{$past(blk), SLOT_W'(HOLD_N-1)}] == $past(wdata_flat[HOLD_N*8-1 -: 8])));

endmodule

// File: rtl/flw_seq.sv
module flw_seq
  import flw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int HOLD_N      = 8,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_ld,
  input  logic [ADDR_W-1:0] ptr_wdata,
  input  logic              tw_we,
  input  logic [7:0]        tw_data,
  input  logic              tw_inc,
  input  logic              key_we,
  input  logic [7:0]        key_data,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [7:0]        ctl_rdata,
  output logic              stall
);

  localparam int SLOT_W = $clog2(HOLD_N);
  localparam int BLK_W  = ADDR_W - SLOT_W;

  logic              busy, done, en;
  logic              start_wr, other_acc, armed_hit;
  logic              go, err_evt, no_target;
  ctl_t              ctl_q, ctl_w;
  ul_state_t         ul_state;
  logic [HOLD_N*8-1:0] hold_flat;
  logic [ADDR_W-1:0] ptr_q;
  logic [BLK_W-1:0]  blk;

  assign en        = !busy;
  assign ctl_w     = ctl_from_bus(ctl_wdata);
  assign start_wr  = ctl_we && ctl_w.start;
  assign other_acc = tw_we || ptr_ld || (ctl_we && !ctl_w.start);

  // named commit events
  assign go        = armed_hit && ctl_w.wren && aims_at_program(ctl_w);
  assign err_evt   = armed_hit && !ctl_w.wren;
  assign no_target = armed_hit && ctl_w.wren && !aims_at_program(ctl_w);
  assign blk       = ptr_q[ADDR_W-1:SLOT_W];

  flw_unlock u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .key_we    (key_we),
    .key_data  (key_data),
    .other_acc (other_acc),
    .start_wr  (start_wr),
    .armed_hit (armed_hit),
    .state_o   (ul_state)
  );

  flw_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .busy  (busy),
    .done  (done)
  );

  flw_holding #(.ADDR_W(ADDR_W), .HOLD_N(HOLD_N)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ptr_ld    (ptr_ld),
    .ptr_wdata (ptr_wdata),
    .tw_we     (tw_we),
    .tw_data   (tw_data),
    .tw_inc    (tw_inc),
    .refill    (done),
    .ptr_o     (ptr_q),
    .hold_flat (hold_flat)
  );

  flw_array #(.ADDR_W(ADDR_W), .HOLD_N(HOLD_N)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (done),
    .blk        (blk),
    .wdata_flat (hold_flat),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (done) begin
      ctl_q.start <= 1'b0;
    end else if (en && ctl_we) begin
      ctl_q.wren     <= ctl_w.wren;
      ctl_q.prog_sel <= ctl_w.prog_sel;
      ctl_q.cfg_sel  <= ctl_w.cfg_sel;
      ctl_q.start    <= go;
      if (err_evt)  ctl_q.err <= 1'b1;
      else if (go)  ctl_q.err <= 1'b0;
    end
  end

  assign ctl_rdata = ctl_to_bus(ctl_q);
  assign ptr_o     = ptr_q;
  assign stall     = busy;

  // R3: a valid armed start freezes the core next cycle with start set
  p_commit_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (stall && ctl_q.start));

  // R4: a start write outside the armed state does nothing
  p_unarmed_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_wr && ul_state != UL_ARMED) |=> (!stall && !ctl_q.start));

  // R5: wrong target starts nothing and keeps the error flag
  p_wrong_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    no_target |=> (!stall && ctl_q.err == $past(ctl_q.err)));

  // R6: disabled write flags an error and never stalls
  p_err_noprog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> (!stall && ctl_q.err));

  // R7: start bit reads set for the whole long write
  p_start_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ctl_q.start);

  // R7: start bit clears as the long write ends
  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> !ctl_q.start);

  // R10: control image frozen while the core is held
  p_ctl_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> $stable(ctl_q));

  // R11: a started commit leaves no error behind
  p_err_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !ctl_q.err);

endmodule

// File: tb/flw_seq_tb.sv
`timescale 1ns/100ps
module flw_seq_tb;

  localparam int ADDR_W = 6;
  localparam int PC     = 16;
  localparam int DEPTH  = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ptr_ld, tw_we, tw_inc, key_we, ctl_we;
  logic [ADDR_W-1:0] ptr_wdata, rd_addr;
  logic [7:0]        tw_data, key_data, ctl_wdata;
  logic [7:0]        rd_data, ctl_rdata;
  logic [ADDR_W-1:0] ptr_o;
  logic              stall;

  int checks = 0;
  int errors = 0;

  logic [7:0]        exp_mem [DEPTH];
  logic [7:0]        hold_m  [8];
  logic [ADDR_W-1:0] m_ptr;

  // scattered loads into block 1: {pointer, byte}
  localparam logic [13:0] VEC [8] = '{
    {6'd13, 8'hA5}, {6'd8,  8'h01}, {6'd15, 8'h7E}, {6'd10, 8'h3C},
    {6'd9,  8'h00}, {6'd14, 8'hC3}, {6'd11, 8'h5A}, {6'd12, 8'h96}
  };

  always #2.5 clk = ~clk;

  flw_seq #(.ADDR_W(ADDR_W), .HOLD_N(8), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_wdata(ptr_wdata),
    .tw_we(tw_we), .tw_data(tw_data), .tw_inc(tw_inc),
    .key_we(key_we), .key_data(key_data), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .ptr_o(ptr_o),
    .ctl_rdata(ctl_rdata), .stall(stall)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_array(input string req);
    int bad_a = -1;
    int bad_v = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = ADDR_W'(a);
      #0.1;
      if (bad_a < 0 && rd_data !== exp_mem[a]) begin
        bad_a = a;
        bad_v = int'(rd_data);
      end
    end
    if (bad_a < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, {req, " array byte"}, bad_v, int'(exp_mem[bad_a]));
  endtask

  task automatic op_ptr(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    if (!stall) m_ptr = a;
    ptr_ld = 1'b1; ptr_wdata = a;
    @(negedge clk);
    ptr_ld = 1'b0;
  endtask

  task automatic op_tw(input logic [7:0] d, input logic inc);
    @(negedge clk);
    if (!stall) begin
      hold_m[m_ptr[2:0]] = d;
      if (inc) m_ptr = m_ptr + 1'b1;
    end
    tw_we = 1'b1; tw_data = d; tw_inc = inc;
    @(negedge clk);
    tw_we = 1'b0; tw_inc = 1'b0;
  endtask

  task automatic op_key(input logic [7:0] d);
    @(negedge clk);
    key_we = 1'b1; key_data = d;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic op_ctl(input logic [7:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic unlock();
    op_key(8'h55);
    op_key(8'hAA);
  endtask

  task automatic model_commit();
    for (int i = 0; i < 8; i++) begin
      exp_mem[{m_ptr[ADDR_W-1:3], 3'(i)}] = hold_m[i];
      hold_m[i] = 8'hFF;
    end
  endtask

  task automatic commit_ok();
    int n = 0;
    int lost = 0;
    unlock();
    op_ctl(8'h07);
    chk(stall === 1'b1, "R3 stall after unlock+start", int'(stall), 1);
    while (stall === 1'b1) begin
      if (ctl_rdata[0] !== 1'b1) lost++;
      n++;
      @(negedge clk);
    end
    chk(n == PC, "R7 stall length", n, PC);
    chk(lost == 0, "R7 start bit during write", lost, 0);
    chk(ctl_rdata[0] === 1'b0, "R7 start bit after write", int'(ctl_rdata[0]), 0);
    model_commit();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ptr_ld = 0; tw_we = 0; tw_inc = 0; key_we = 0; ctl_we = 0;
    ptr_wdata = '0; tw_data = '0; key_data = '0; ctl_wdata = '0; rd_addr = '0;
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    for (int i = 0; i < 8; i++) hold_m[i] = 8'hFF;
    m_ptr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(stall === 1'b0, "R1 stall", int'(stall), 0);
    chk(ctl_rdata === 8'h00, "R1 control", int'(ctl_rdata), 0);
    chk(ptr_o === '0, "R1 pointer", int'(ptr_o), 0);
    check_array("R1 erased array");

    // R2 vector walk: scattered byte loads
    for (int i = 0; i < 8; i++) begin
      op_ptr(VEC[i][13:8]);
      op_tw(VEC[i][7:0], 1'b0);
    end
    chk(ptr_o === 6'd12, "R2 pointer without increment", int'(ptr_o), 12);
    check_array("R2 no array change from table writes");

    // R3 R7 R8 full block commit
    commit_ok();
    check_array("R8 block 1 contents");

    // R9 partial reload with auto-increment
    op_ptr(6'd16);
    op_tw(8'h11, 1'b1);
    op_tw(8'h22, 1'b1);
    chk(ptr_o === 6'd18, "R2 pointer increment", int'(ptr_o), 18);
    commit_ok();
    check_array("R9 partial block gets erased bytes");

    // R10 accesses while stalled
    op_ptr(6'd24);
    op_tw(8'h33, 1'b0);
    unlock();
    op_ctl(8'h07);
    chk(stall === 1'b1, "R3 stall for frozen test", int'(stall), 1);
    op_ptr(6'd40);
    op_tw(8'h44, 1'b1);
    op_key(8'h55);
    op_ctl(8'h02);
    chk(ptr_o === 6'd24, "R10 pointer frozen", int'(ptr_o), 24);
    chk(ctl_rdata === 8'h07, "R10 control frozen", int'(ctl_rdata), 7);
    while (stall === 1'b1) @(negedge clk);
    model_commit();
    check_array("R10 table write during stall ignored");

    // R4 start without unlock
    op_ptr(6'd32);
    op_tw(8'h5A, 1'b0);
    op_ctl(8'h07);
    chk(stall === 1'b0, "R4 start without unlock", int'(stall), 0);
    chk(ctl_rdata[0] === 1'b0, "R4 start bit stays clear", int'(ctl_rdata[0]), 0);
    // R4 wrong key byte
    op_key(8'h55); op_key(8'h56); op_key(8'hAA);
    op_ctl(8'h07);
    chk(stall === 1'b0, "R4 wrong key byte", int'(stall), 0);
    // R4 table write between key bytes
    op_key(8'h55); op_tw(8'h5B, 1'b0); op_key(8'hAA);
    op_ctl(8'h07);
    chk(stall === 1'b0, "R4 table write between keys", int'(stall), 0);
    // R4 pointer load between unlock and start
    unlock(); op_ptr(6'd32);
    op_ctl(8'h07);
    chk(stall === 1'b0, "R4 pointer load before start", int'(stall), 0);
    check_array("R4 array unchanged");

    // R6 write enable clear
    unlock();
    op_ctl(8'h05);
    chk(stall === 1'b0, "R6 no stall", int'(stall), 0);
    chk(ctl_rdata[4] === 1'b1, "R6 error flag", int'(ctl_rdata[4]), 1);
    check_array("R6 array unchanged");

    // R5 wrong target
    unlock();
    op_ctl(8'h0F);
    chk(stall === 1'b0, "R5 configuration selected", int'(stall), 0);
    chk(ctl_rdata[4] === 1'b1, "R5 error flag kept", int'(ctl_rdata[4]), 1);
    unlock();
    op_ctl(8'h03);
    chk(stall === 1'b0, "R5 program not selected", int'(stall), 0);
    check_array("R5 array unchanged");

    // R11 successful commit clears the error flag
    commit_ok();
    chk(ctl_rdata[4] === 1'b0, "R11 error cleared", int'(ctl_rdata[4]), 0);
    check_array("R11 block 4 contents");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule